// File: doc/BRIEF.md
# Half-Bridge Gate Driver Control Logic

This block is the synchronous decision logic that sits between a controller and the two gate drive stages of a half bridge. It takes the requested high-side and low-side switch commands, a fault-clear request, an over-current comparator flag, the sensed level of a shared wired-AND fault line, a supply power-good flag and a high-side supply-good flag. From these it produces the two drive commands and an enable that pulls the shared fault line low.

Each slow control input is brought into the clock domain through two flops. The switch requests, the fault-clear request and the sensed fault line are then passed through a glitch filter that only accepts a level held for `FILT_LEN` clocks. The block prevents cross-conduction: a pair of simultaneous requests holds the previous drive, and a simultaneous rise favours the high side. An over-current while the low side is requested latches a fault, which shuts both outputs and pulls the shared line low. A low level on the shared line, from any phase or from the controller, shuts both outputs. A power-reset shuts both outputs, and a sustained high-side supply drop locks the high side. After any shutdown a channel drives again only after its request has been seen low and then high.

Top module: `hb_gate_ctrl`

## Requirements
- R1: A level change on `hin_i`, `lin_i`, `frst_i` or `flt_sense_i` is accepted only after it has been held for `FILT_LEN` consecutive clocks; shorter pulses have no effect. A held change on `hin_i` reaches `hout_o` exactly `FILT_LEN`+3 clocks after it is applied.
- R2: With no shutdown active, a single high request drives only its own output high, two low requests drive both outputs low, and two high requests hold the previous pair of outputs.
- R3: When both filtered requests rise in the same clock from both low, `hout_o` goes high and `lout_o` stays low.
- R4: When a both-high period ends with one request dropping, the outputs settle to the pair that matches the request still high.
- R5: `ocp_i` high while the filtered low-side request is high sets the fault latch: `flt_pull_o` goes to 1 and both outputs go low.
- R6: `ocp_i` high while the filtered low-side request is low changes neither output nor `flt_pull_o`.
- R7: The fault latch is cleared by a filtered high on `frst_i` (or by a power-reset); `flt_pull_o` then returns to 0, and an output still requested stays low until its request is seen low and then high.
- R8: A low on `flt_sense_i` forces both outputs low; after it returns high, an output still requested stays low until a fresh rising request.
- R9: `por_ok_i` low forces both outputs low and clears the fault latch; after it returns high, outputs respond only to fresh rising requests.
- R10: `hs_supply_ok_i` low for at least `UV_FILT_LEN` synchronized clocks locks `hout_o` low without affecting `lout_o`; shorter drops are ignored; after the supply recovers `hout_o` waits for a fresh rising `hin_i`.
- R11: `hout_o` and `lout_o` are never high in the same cycle.
- R12: After reset both outputs are low and `flt_pull_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hin_i | input | 1 | High-side switch request, asynchronous |
| lin_i | input | 1 | Low-side switch request, asynchronous |
| frst_i | input | 1 | Fault-clear request, asynchronous, active high |
| ocp_i | input | 1 | Over-current comparator flag, active high |
| flt_sense_i | input | 1 | Sensed level of the shared fault line, low means fault |
| por_ok_i | input | 1 | Supply power-good, low means power-reset |
| hs_supply_ok_i | input | 1 | High-side supply good, low means undervoltage |
| hout_o | output | 1 | High-side drive command |
| lout_o | output | 1 | Low-side drive command |
| flt_pull_o | output | 1 | Open-drain enable: 1 pulls the shared fault line low |

## Verification
The assertions assume reset is held for several clocks before the first check so that the synchronizer and filter registers hold their idle levels, and that the shared fault line reflects `flt_pull_o` combined with any external pull-down. The bench closes that loop with a wired-AND model of the line, keeps the clock-to-clock spacing of every stimulus either clearly below or clearly above the filter lengths except in the deliberate boundary pulses, and lets each stimulus settle for longer than the full sync-plus-filter latency before sampling. The request sweep walks every ordered pair of the four request patterns so that holds, simultaneous rises and both-high exits are all reached from known outputs.

// File: rtl/hb_gate_pkg.sv
// Shared types and helpers for the half-bridge gate control block.
package hb_gate_pkg;

    // Pair of drive commands, high side and low side.
    typedef struct packed {
        logic hi;
        logic lo;
    } hb_pair_t;

    // Counter width able to hold 0 .. n-1, never below one bit.
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/hb_sync_filter.sv
// Two-flop synchronizer followed by an optional level glitch filter.
// With LEN == 0 only the synchronizer is built. With LEN > 0 the output
// takes a new level only after the synchronized input has differed from
// it for LEN consecutive clocks. Assumes din is asynchronous to clk.
module hb_sync_filter
    import hb_gate_pkg::*;
#(
    parameter int unsigned LEN     = 4,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic meta_q;
    logic sync_q;

    // Bring the asynchronous level into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            sync_q <= RST_VAL;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
        end
    end

    generate
        if (LEN == 0) begin : g_sync_only
            assign dout = sync_q;
        end else begin : g_filter
            localparam int unsigned CW = cnt_width(LEN);
            localparam logic [CW-1:0] LAST = CW'(LEN - 1);

            logic [CW-1:0] run_q;
            logic          lvl_q;

            // Count clocks of disagreement; accept the new level at LEN.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    run_q <= '0;
                    lvl_q <= RST_VAL;
                end else if (sync_q == lvl_q) begin
                    run_q <= '0;
                end else if (run_q == LAST) begin
                    run_q <= '0;
                    lvl_q <= sync_q;
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end

            assign dout = lvl_q;

            // R1: the accepted level only moves toward the synchronized input.
            a_r1_follows_sync: assert property (@(posedge clk) disable iff (!rst_n)
                (lvl_q != $past(lvl_q)) |-> (lvl_q == $past(sync_q)));
        end
    endgenerate

endmodule

// File: rtl/hb_uv_lock.sv
// High-side undervoltage lockout qualifier. Raises lock after uv_bad has
// been high for LEN consecutive clocks and drops it as soon as uv_bad is
// low. Assumes uv_bad is already synchronized and LEN >= 1.
module hb_uv_lock
    import hb_gate_pkg::*;
#(
    parameter int unsigned LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic uv_bad,
    output logic lock
);

    localparam int unsigned CW = cnt_width(LEN);
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    logic [CW-1:0] dwell_q;
    logic          lock_q;

    // Measure the undervoltage dwell and hold the lock while it persists.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dwell_q <= '0;
            lock_q  <= 1'b0;
        end else if (!uv_bad) begin
            dwell_q <= '0;
            lock_q  <= 1'b0;
        end else if (!lock_q) begin
            if (dwell_q == LAST) begin
                lock_q <= 1'b1;
            end else begin
                dwell_q <= dwell_q + 1'b1;
            end
        end
    end

    assign lock = lock_q;

    // R10: a lock only appears while the supply is reported bad.
    a_r10_lock_needs_bad: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_q) |-> $past(uv_bad));

endmodule

// File: rtl/hb_fault_latch.sv
// Over-current fault latch. Sets on an over-current flag while the
// filtered low-side request is high, clears on a filtered clear request or
// on power-reset. Setting wins over clearing. Assumes synchronized inputs.
module hb_fault_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic ocp,
    input  logic lin_f,
    input  logic clr_f,
    input  logic por_ok,
    output logic fault
);

    logic fault_q;
    logic trip;

    // Over-current counts only with the low side requested and power good.
    always_comb begin
        trip = ocp && lin_f && por_ok;
    end

    // Hold the fault until it is explicitly cleared.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q <= 1'b0;
        end else if (!por_ok) begin
            fault_q <= 1'b0;
        end else if (trip) begin
            fault_q <= 1'b1;
        end else if (clr_f) begin
            fault_q <= 1'b0;
        end
    end

    assign fault = fault_q;

    // R6: a fault is only ever raised by over-current with low side requested.
    a_r6_trip_needs_lin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_q) |-> $past(ocp && lin_f));

    // R7: a fault only goes away through a clear request or power-reset.
    a_r7_clear_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_q) |-> $past(clr_f || !por_ok));

endmodule

// File: rtl/hb_interlock.sv
// Cross-conduction interlock and re-arm logic for the two drive channels.
// Both high holds the previous drive, a simultaneous rise favours the high
// side, and after a shutdown a channel must see its request low before it
// may drive again. Assumes filtered, synchronous requests.
module hb_interlock
    import hb_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hin_f,
    input  logic lin_f,
    input  logic kill_all,
    input  logic uv_lock,
    output logic hout,
    output logic lout
);

    logic     h_q, l_q;
    logic     arm_h_q, arm_l_q;
    logic     kill_hi;
    logic     h_eff, l_eff, both_rise;
    hb_pair_t drv_q, drv_d;

    // Work out the next drive pair from requests, arming and shutdowns.
    always_comb begin
        kill_hi   = kill_all || uv_lock;
        h_eff     = hin_f && arm_h_q;
        l_eff     = lin_f && arm_l_q;
        both_rise = hin_f && !h_q && lin_f && !l_q;
        if (h_eff && l_eff) begin
            drv_d = both_rise ? hb_pair_t'{hi: 1'b1, lo: 1'b0} : drv_q;
        end else begin
            drv_d = hb_pair_t'{hi: h_eff, lo: l_eff};
        end
        if (kill_hi) begin
            drv_d.hi = 1'b0;
        end
        if (kill_all) begin
            drv_d.lo = 1'b0;
        end
    end

    // Register the drive pair and the previous requests for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_q <= '0;
            h_q   <= 1'b0;
            l_q   <= 1'b0;
        end else begin
            drv_q <= drv_d;
            h_q   <= hin_f;
            l_q   <= lin_f;
        end
    end

    // Disarm on shutdown; re-arm once the request is seen low afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_h_q <= 1'b0;
            arm_l_q <= 1'b0;
        end else begin
            arm_h_q <= kill_hi  ? 1'b0 : (arm_h_q || !hin_f);
            arm_l_q <= kill_all ? 1'b0 : (arm_l_q || !lin_f);
        end
    end

    assign hout = drv_q.hi;
    assign lout = drv_q.lo;

    // R11: never drive both switches of the bridge at once.
    a_r11_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(drv_q.hi && drv_q.lo));

    // R8: the high side only turns on from an armed state.
    a_r8_hi_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_q.hi) |-> $past(arm_h_q));

    // R8: the low side only turns on from an armed state.
    a_r8_lo_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_q.lo) |-> $past(arm_l_q));

endmodule

// File: rtl/hb_gate_ctrl.sv
// Top of the half-bridge gate control logic. Synchronizes every control
// input, filters the requests and the sensed fault line, and combines the
// fault latch, the shared line, power-reset and high-side lockout into the
// shutdown terms for the interlock. The fault line is open drain: the block
// only enables a pull-down and reads the line back through its filter.
module hb_gate_ctrl
    import hb_gate_pkg::*;
#(
    parameter int unsigned FILT_LEN    = 50,
    parameter int unsigned UV_FILT_LEN = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hin_i,
    input  logic lin_i,
    input  logic frst_i,
    input  logic ocp_i,
    input  logic flt_sense_i,
    input  logic por_ok_i,
    input  logic hs_supply_ok_i,
    output logic hout_o,
    output logic lout_o,
    output logic flt_pull_o
);

    // Filtered inputs: 0 high request, 1 low request, 2 clear, 3 line sense.
    localparam int unsigned   NFILT     = 4;
    localparam logic [NFILT-1:0] FILT_IDLE = 4'b1000;
    // Sync-only inputs: 0 over-current, 1 power good, 2 supply bad.
    localparam int unsigned   NSYNC     = 3;
    localparam logic [NSYNC-1:0] SYNC_IDLE = 3'b010;

    logic [NFILT-1:0] filt_raw, filt_out;
    logic [NSYNC-1:0] sync_raw, sync_out;
    logic             hs_bad;
    logic             uv_lock;
    logic             fault;
    logic             kill_all;

    assign hs_bad   = !hs_supply_ok_i;
    assign filt_raw = {flt_sense_i, frst_i, lin_i, hin_i};
    assign sync_raw = {hs_bad, por_ok_i, ocp_i};

    generate
        for (genvar g = 0; g < NFILT; g++) begin : g_filt
            hb_sync_filter #(
                .LEN     (FILT_LEN),
                .RST_VAL (FILT_IDLE[g])
            ) u_filt (
                .clk  (clk),
                .rst_n(rst_n),
                .din  (filt_raw[g]),
                .dout (filt_out[g])
            );
        end
        for (genvar s = 0; s < NSYNC; s++) begin : g_sync
            hb_sync_filter #(
                .LEN     (0),
                .RST_VAL (SYNC_IDLE[s])
            ) u_sync (
                .clk  (clk),
                .rst_n(rst_n),
                .din  (sync_raw[s]),
                .dout (sync_out[s])
            );
        end
    endgenerate

    hb_uv_lock #(
        .LEN(UV_FILT_LEN)
    ) u_uv (
        .clk   (clk),
        .rst_n (rst_n),
        .uv_bad(sync_out[2]),
        .lock  (uv_lock)
    );

    hb_fault_latch u_fault (
        .clk   (clk),
        .rst_n (rst_n),
        .ocp   (sync_out[0]),
        .lin_f (filt_out[1]),
        .clr_f (filt_out[2]),
        .por_ok(sync_out[1]),
        .fault (fault)
    );

    // Any of these conditions removes drive from both channels.
    always_comb begin
        kill_all = !sync_out[1] || fault || !filt_out[3];
    end

    hb_interlock u_ilk (
        .clk     (clk),
        .rst_n   (rst_n),
        .hin_f   (filt_out[0]),
        .lin_f   (filt_out[1]),
        .kill_all(kill_all),
        .uv_lock (uv_lock),
        .hout    (hout_o),
        .lout    (lout_o)
    );

    assign flt_pull_o = fault;

    // R5: once the line is being pulled, both outputs are off next cycle.
    a_r5_pull_kills: assert property (@(posedge clk) disable iff (!rst_n)
        flt_pull_o |=> (!hout_o && !lout_o));

    // R8: a low sensed fault line removes both drives.
    a_r8_line_kills: assert property (@(posedge clk) disable iff (!rst_n)
        !filt_out[3] |=> (!hout_o && !lout_o));

    // R9: power-reset removes both drives.
    a_r9_por_kills: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_out[1] |=> (!hout_o && !lout_o));

    // R10: high-side lockout removes the high drive.
    a_r10_uv_kills: assert property (@(posedge clk) disable iff (!rst_n)
        uv_lock |=> !hout_o);

endmodule

// File: tb/hb_gate_ctrl_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: short filters, every ordered pair of request
// patterns, and each shutdown path with its release condition.
module hb_gate_ctrl_tb_top;

    localparam int unsigned FL = 4;
    localparam int unsigned UL = 8;
    localparam int unsigned SETTLE = FL + 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hin = 1'b0, lin = 1'b0, frst = 1'b0, ocp = 1'b0;
    logic ext_pull = 1'b0, por_ok = 1'b1, hs_ok = 1'b1;
    logic hout, lout, pull;
    logic line;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    // Wired-AND shared fault line.
    assign line = !(pull || ext_pull);

    hb_gate_ctrl #(.FILT_LEN(FL), .UV_FILT_LEN(UL)) dut_i (
        .clk(clk), .rst_n(rst_n), .hin_i(hin), .lin_i(lin), .frst_i(frst),
        .ocp_i(ocp), .flt_sense_i(line), .por_ok_i(por_ok),
        .hs_supply_ok_i(hs_ok), .hout_o(hout), .lout_o(lout), .flt_pull_o(pull)
    );

    task automatic wait_n(input int unsigned n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle();
        wait_n(SETTLE);
    endtask

    // Compare {hout, lout, pull} against the expected triple.
    task automatic chk(input string tag, input logic [2:0] exp);
        logic [2:0] act;
        act = {hout, lout, pull};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic ocp_pulse();
        ocp = 1'b1;
        wait_n(3);
        ocp = 1'b0;
    endtask

    // Bench model of the request interlock (R2, R3, R4, R11).
    logic [1:0] pin_prev = 2'b00;
    logic [1:0] exp_out  = 2'b00;

    task automatic apply_pair(input logic [1:0] v);
        string tag;
        hin = v[1];
        lin = v[0];
        settle();
        if (v == 2'b11) begin
            if (pin_prev == 2'b00) begin
                exp_out = 2'b10;
                tag = "R3 simultaneous rise";
            end else begin
                tag = "R2 both-high hold";
            end
        end else begin
            exp_out = v;
            tag = (pin_prev == 2'b11) ? "R4 leave both-high" : "R2 follow request";
        end
        pin_prev = v;
        chk(tag, {exp_out, 1'b0});
    endtask

    logic done = 1'b0;

    initial begin
        wait_n(5);
        rst_n = 1'b1;
        settle();
        chk("R12 reset state", 3'b000);

        // R1: exact latency of an accepted request.
        hin = 1'b1;
        wait_n(FL + 2);
        chk("R1 latency before", 3'b000);
        wait_n(1);
        chk("R1 latency at", 3'b100);
        hin = 1'b0;
        settle();
        chk("R1 release", 3'b000);

        // R1: short request pulse rejected.
        hin = 1'b1;
        wait_n(FL - 1);
        hin = 1'b0;
        settle();
        chk("R1 short request", 3'b000);

        // R1: short fault-line glitch rejected.
        hin = 1'b1;
        settle();
        ext_pull = 1'b1;
        wait_n(FL - 1);
        ext_pull = 1'b0;
        settle();
        chk("R1 short line glitch", 3'b100);
        hin = 1'b0;
        settle();

        // R2 R3 R4 R11: every ordered pair of request patterns.
        pin_prev = 2'b00;
        exp_out  = 2'b00;
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                apply_pair(2'(a));
                apply_pair(2'(b));
            end
        end
        hin = 1'b0;
        lin = 1'b0;
        settle();

        // R5: over-current with low side requested.
        lin = 1'b1;
        settle();
        chk("R5 low side on", 3'b010);
        ocp_pulse();
        settle();
        chk("R5 trip", 3'b001);

        // R7: short clear ignored, real clear releases, fresh edge needed.
        frst = 1'b1;
        wait_n(FL - 1);
        frst = 1'b0;
        settle();
        chk("R7 short clear", 3'b001);
        frst = 1'b1;
        wait_n(FL + 2);
        frst = 1'b0;
        settle();
        chk("R7 cleared no edge", 3'b000);
        lin = 1'b0;
        settle();
        lin = 1'b1;
        settle();
        chk("R7 fresh edge", 3'b010);
        lin = 1'b0;
        settle();

        // R6: over-current with low side idle.
        hin = 1'b1;
        settle();
        ocp_pulse();
        settle();
        chk("R6 ignored", 3'b100);

        // R8: external pull-down of the shared line.
        ext_pull = 1'b1;
        settle();
        chk("R8 line low", 3'b000);
        ext_pull = 1'b0;
        settle();
        chk("R8 released no edge", 3'b000);
        hin = 1'b0;
        settle();
        hin = 1'b1;
        settle();
        chk("R8 fresh edge", 3'b100);
        hin = 1'b0;
        settle();

        // R9: power-reset clears fault and drive.
        lin = 1'b1;
        settle();
        ocp_pulse();
        settle();
        chk("R9 pre trip", 3'b001);
        por_ok = 1'b0;
        settle();
        chk("R9 power reset", 3'b000);
        por_ok = 1'b1;
        settle();
        chk("R9 recovered no edge", 3'b000);
        lin = 1'b0;
        settle();
        lin = 1'b1;
        settle();
        chk("R9 fresh edge", 3'b010);
        lin = 1'b0;
        settle();

        // R10: high-side supply lockout.
        hin = 1'b1;
        settle();
        hs_ok = 1'b0;
        wait_n(UL - 1);
        hs_ok = 1'b1;
        settle();
        chk("R10 short drop", 3'b100);
        hs_ok = 1'b0;
        wait_n(UL + SETTLE);
        chk("R10 locked", 3'b000);
        hin = 1'b0;
        lin = 1'b1;
        settle();
        chk("R10 low side free", 3'b010);
        lin = 1'b0;
        hin = 1'b1;
        settle();
        chk("R10 still locked", 3'b000);
        hs_ok = 1'b1;
        settle();
        chk("R10 recovered no edge", 3'b000);
        hin = 1'b0;
        settle();
        hin = 1'b1;
        settle();
        chk("R10 fresh edge", 3'b100);
        hin = 1'b0;
        settle();

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule